// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block buffers words between two unrelated clock domains. A producer pushes one word on each write-clock rising edge for which its enable is high, and a consumer pops one word per read-clock rising edge for which its enable is high. Popped words land in an output register. That register drives the read bus while the output enable is active. When the output enable is inactive, the bus floats.

Five active-low level indicators describe how full the buffer is: empty, full, more-than-half, almost-empty and almost-full. The two "almost" thresholds come from offset values that a separate loader supplies. A timing-mode input is sampled while the master reset is held. It decides whether the almost flags go through a register stage or follow the occupancy count directly.

There are two reset inputs. The master reset returns the whole block to its defaults. The partial reset empties the buffer and keeps the chosen timing mode. Depth is 2^AW words and data width is DW bits.

Top module: `pflag_fifo`

## Requirements
- R1: A word is stored only on a write-clock rising edge with `wr_en` high, and a word is popped only on a read-clock rising edge with `rd_en` high. Words come out in the order they went in. `rd_data` keeps its value between pops.
- R2: While `mrst_n` is low, both pointers are zero and the output register is zero. After release the flags read empty (`empty_n`=0, `aempty_n`=0, `full_n`=1, `half_n`=1, `afull_n`=1).
- R3: A write while full and a read while empty are dropped. Neither pointer moves, stored contents are kept and `rd_data` is unchanged.
- R4: `empty_n` is 0 exactly when the occupancy is 0. `full_n` is 0 exactly when the occupancy is 2^AW.
- R5: `half_n` is 0 exactly when the occupancy exceeds 2^(AW-1).
- R6: `aempty_n` is 0 exactly when the occupancy is at most `ae_offset`, read as an unsigned AW-bit number.
- R7: `afull_n` is 0 exactly when the occupancy is at least 2^AW minus `af_offset`, with `af_offset` read as an unsigned AW-bit number.
- R8: A low pulse on `prst_n` empties the buffer, zeroes both pointers and the output register, and keeps the timing mode captured at master reset.
- R9: `sync_mode_sel` is sampled on write-clock edges while `mrst_n` is low.
  - With a 1, `afull_n` reacts one write-clock edge after the write that crosses its threshold, and `aempty_n` reacts one read-clock edge after the read that crosses its threshold.
  - With a 0, each flag reacts at the same edge as the write or read that crosses its threshold.
- R10: With `oe_n` high, every bit of `rd_data` is high impedance. With `oe_n` low, `rd_data` shows the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | DW | Word to store |
| rd_clk | input | 1 | Read clock |
| rd_en | input | 1 | Read enable, active high |
| oe_n | input | 1 | Read bus drive enable, active low |
| rd_data | output | DW | Output register, or high impedance |
| mrst_n | input | 1 | Master reset, active low, asynchronous |
| prst_n | input | 1 | Partial reset, active low, asynchronous |
| sync_mode_sel | input | 1 | Almost-flag timing choice, sampled during master reset |
| ae_offset | input | AW | Almost-empty offset |
| af_offset | input | AW | Almost-full offset |
| empty_n | output | 1 | Low when empty |
| full_n | output | 1 | Low when full |
| half_n | output | 1 | Low when above half |
| aempty_n | output | 1 | Low when at or below the almost-empty offset |
| afull_n | output | 1 | Low when within the almost-full offset of full |

## Verification
The bench builds the block with AW=3 and DW=16, which gives an eight-word buffer. At that size every occupancy from 0 to 8 can be reached one word at a time, and each flag is compared with its arithmetic definition at every level. The offsets are swept across both extremes, 0 and 7, and a middle value, under both timing modes. The small depth also puts the overflow and underflow edges, the partial-reset retention and the one-edge mode difference within a few cycles of one another.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;
  typedef enum logic {
    FLAG_ASYNC = 1'b0,
    FLAG_SYNC  = 1'b1
  } flag_timing_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/pfifo_sync.sv
// Multi-stage synchronizer; with d tied high it serves as a reset releaser.
module pfifo_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_nxt;
    if (s == 0) begin : g_first
      assign stage_nxt = d;
    end else begin : g_rest
      assign stage_nxt = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_nxt;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pfifo_gray2bin.sv
// Gray to binary: each bit is the XOR of itself and all higher Gray bits.
module pfifo_gray2bin #(
  parameter int W = 4
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin[i] = ^gray[W-1:i];
  end
endmodule

// File: rtl/pfifo_wr_side.sv
// Write-domain pointer, full, half and almost-full logic.
module pfifo_wr_side #(
  parameter int AW = 10
) (
  input  logic          wr_clk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_sync,
  input  logic [AW-1:0] af_offset,
  input  logic          sync_mode,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic          wr_fire,
  output logic          full_n,
  output logic          half_n,
  output logic          afull_n
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = {1'b1, {AW{1'b0}}};
  localparam logic [PW-1:0] HALF_P  = DEPTH_P >> 1;

  logic [PW-1:0] rbin_s, wbin_q, wbin_nxt, wgray_q, wgray_nxt;
  logic [PW-1:0] cnt_now, cnt_nxt, af_thr;
  logic          full_n_q, full_n_nxt, half_n_q, half_n_nxt;
  logic          af_reg_n_q, af_reg_n_nxt, af_level;

  pfifo_gray2bin #(.W(PW)) u_rd_g2b (.gray(rgray_sync), .bin(rbin_s));

  always_comb begin
    wr_fire      = wr_en & full_n_q;               // R3: drop when full
    wbin_nxt     = wbin_q + PW'(wr_fire);
    wgray_nxt    = wbin_nxt ^ (wbin_nxt >> 1);
    cnt_now      = wbin_q - rbin_s;
    cnt_nxt      = wbin_nxt - rbin_s;
    af_thr       = DEPTH_P - {1'b0, af_offset};
    full_n_nxt   = (cnt_nxt != DEPTH_P);           // R4
    half_n_nxt   = !(cnt_now > HALF_P);            // R5
    af_level     = (cnt_now >= af_thr);            // R7
    af_reg_n_nxt = ~af_level;
  end

  always_ff @(posedge wr_clk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q     <= '0;
      wgray_q    <= '0;
      full_n_q   <= 1'b1;
      half_n_q   <= 1'b1;
      af_reg_n_q <= 1'b1;
    end else begin
      wbin_q     <= wbin_nxt;
      wgray_q    <= wgray_nxt;
      full_n_q   <= full_n_nxt;
      half_n_q   <= half_n_nxt;
      af_reg_n_q <= af_reg_n_nxt;
    end
  end

  assign wbin    = wbin_q;
  assign wgray   = wgray_q;
  assign full_n  = full_n_q;
  assign half_n  = half_n_q;
  assign afull_n = sync_mode ? af_reg_n_q : ~af_level;   // R9
endmodule

// File: rtl/pfifo_rd_side.sv
// Read-domain pointer, empty and almost-empty logic.
module pfifo_rd_side #(
  parameter int AW = 10
) (
  input  logic          rd_clk,
  input  logic          rrst_n,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_sync,
  input  logic [AW-1:0] ae_offset,
  input  logic          sync_mode,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic          rd_fire,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wbin_s, rbin_q, rbin_nxt, rgray_q, rgray_nxt;
  logic [PW-1:0] cnt_now, cnt_nxt;
  logic          empty_n_q, empty_n_nxt, ae_reg_n_q, ae_reg_n_nxt, ae_level;

  pfifo_gray2bin #(.W(PW)) u_wr_g2b (.gray(wgray_sync), .bin(wbin_s));

  always_comb begin
    rd_fire      = rd_en & empty_n_q;              // R3: drop when empty
    rbin_nxt     = rbin_q + PW'(rd_fire);
    rgray_nxt    = rbin_nxt ^ (rbin_nxt >> 1);
    cnt_now      = wbin_s - rbin_q;
    cnt_nxt      = wbin_s - rbin_nxt;
    empty_n_nxt  = (cnt_nxt != '0);                // R4
    ae_level     = (cnt_now <= {1'b0, ae_offset}); // R6
    ae_reg_n_nxt = ~ae_level;
  end

  always_ff @(posedge rd_clk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q     <= '0;
      rgray_q    <= '0;
      empty_n_q  <= 1'b0;
      ae_reg_n_q <= 1'b0;
    end else begin
      rbin_q     <= rbin_nxt;
      rgray_q    <= rgray_nxt;
      empty_n_q  <= empty_n_nxt;
      ae_reg_n_q <= ae_reg_n_nxt;
    end
  end

  assign rbin     = rbin_q;
  assign rgray    = rgray_q;
  assign empty_n  = empty_n_q;
  assign aempty_n = sync_mode ? ae_reg_n_q : ~ae_level;  // R9
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
  import pfifo_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_en,
  input  logic          oe_n,
  output logic [DW-1:0] rd_data,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          sync_mode_sel,
  input  logic [AW-1:0] ae_offset,
  input  logic [AW-1:0] af_offset,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n,
  output logic          aempty_n,
  output logic          afull_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic          any_rst_n, wrst_n, rrst_n;
  logic [PW-1:0] wptr_bin, wptr_gray, rptr_bin, rptr_gray;
  logic [PW-1:0] wgray_rd, rgray_wr;
  logic          wr_fire, rd_fire, sync_mode;
  flag_timing_e  mode_q, mode_nxt;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q, rd_q_nxt;

  // Both resets assert asynchronously; release is synchronized per domain.
  assign any_rst_n = mrst_n & prst_n;

  pfifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_wrst (
    .clk(wr_clk), .rst_n(any_rst_n), .d(1'b1), .q(wrst_n));
  pfifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rrst (
    .clk(rd_clk), .rst_n(any_rst_n), .d(1'b1), .q(rrst_n));

  // Timing mode: captured only under master reset, so partial reset keeps it (R8, R9).
  always_comb mode_nxt = mrst_n ? mode_q : flag_timing_e'(sync_mode_sel);
  always_ff @(posedge wr_clk) mode_q <= mode_nxt;
  assign sync_mode = (mode_q == FLAG_SYNC);

  pfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rrst_n), .d(wptr_gray), .q(wgray_rd));
  pfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(wrst_n), .d(rptr_gray), .q(rgray_wr));

  pfifo_wr_side #(.AW(AW)) u_wr (
    .wr_clk(wr_clk), .wrst_n(wrst_n), .wr_en(wr_en), .rgray_sync(rgray_wr),
    .af_offset(af_offset), .sync_mode(sync_mode), .wbin(wptr_bin),
    .wgray(wptr_gray), .wr_fire(wr_fire), .full_n(full_n), .half_n(half_n),
    .afull_n(afull_n));

  pfifo_rd_side #(.AW(AW)) u_rd (
    .rd_clk(rd_clk), .rrst_n(rrst_n), .rd_en(rd_en), .wgray_sync(wgray_rd),
    .ae_offset(ae_offset), .sync_mode(sync_mode), .rbin(rptr_bin),
    .rgray(rptr_gray), .rd_fire(rd_fire), .empty_n(empty_n),
    .aempty_n(aempty_n));

  // Storage array: written in the write domain, no reset.
  always_ff @(posedge wr_clk) begin
    if (wr_fire) mem[wptr_bin[AW-1:0]] <= wr_data;
  end

  // Output register (R1, R2).
  always_comb rd_q_nxt = rd_fire ? mem[rptr_bin[AW-1:0]] : rd_q;

  always_ff @(posedge rd_clk or negedge rrst_n) begin
    if (!rrst_n) rd_q <= '0;
    else         rd_q <= rd_q_nxt;
  end

  assign rd_data = oe_n ? {DW{1'bz}} : rd_q;   // R10
endmodule

// File: rtl/pflag_fifo_checker.sv
module pflag_fifo_checker #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wrst_n,
  input logic          rrst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          full_n,
  input logic          empty_n,
  input logic [AW:0]   wptr,
  input logic [AW:0]   rptr,
  input logic [DW-1:0] rd_q
);
  p_wptr_step_r1: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    (wptr != $past(wptr)) |-> (wptr == $past(wptr) + 1'b1));

  p_rd_hold_r1: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    !(rd_en && empty_n) |=> $stable(rd_q));

  p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    (wr_en && !full_n) |=> $stable(wptr));

  p_no_underflow_r3: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    (rd_en && !empty_n) |=> $stable(rptr));

  p_out_cleared_r2: assert property (@(posedge rd_clk)
    !rrst_n |-> (rd_q == '0 && rptr == '0));
endmodule

bind pflag_fifo pflag_fifo_checker #(.AW(AW), .DW(DW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wrst_n(wrst_n), .rrst_n(rrst_n),
  .wr_en(wr_en), .rd_en(rd_en), .full_n(full_n), .empty_n(empty_n),
  .wptr(wptr_bin), .rptr(rptr_bin), .rd_q(rd_q));

// File: tb/pflag_fifo_test.sv
module pflag_fifo_test;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int N  = 8;

  logic          wr_clk, rd_clk, wr_en, rd_en, oe_n, mrst_n, prst_n, sync_mode_sel;
  logic [DW-1:0] wr_data, rd_data;
  logic [AW-1:0] ae_offset, af_offset;
  logic          empty_n, full_n, half_n, aempty_n, afull_n;

  int checks = 0;
  int fails  = 0;
  int cur_n  = 0;
  int cur_m  = 0;
  bit done   = 0;

  pflag_fifo #(.AW(AW), .DW(DW)) uut (
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data), .rd_clk(rd_clk),
    .rd_en(rd_en), .oe_n(oe_n), .rd_data(rd_data), .mrst_n(mrst_n),
    .prst_n(prst_n), .sync_mode_sel(sync_mode_sel), .ae_offset(ae_offset),
    .af_offset(af_offset), .empty_n(empty_n), .full_n(full_n),
    .half_n(half_n), .aempty_n(aempty_n), .afull_n(afull_n));

  initial begin
    wr_clk = 1'b0;
    forever #10 wr_clk = ~wr_clk;
  end

  initial begin
    rd_clk = 1'b0;
    #7;
    forever #10 rd_clk = ~rd_clk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge wr_clk);
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge wr_clk);
    wr_en   = 1'b0;
  endtask

  task automatic pop();
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
  endtask

  task automatic check_flags(input int c);
    chk("R4 empty_n", 32'(empty_n), 32'(c != 0));
    chk("R4 full_n", 32'(full_n), 32'(c != N));
    chk("R5 half_n", 32'(half_n), 32'(!(c > N / 2)));
    chk("R6 aempty_n", 32'(aempty_n), 32'(!(c <= cur_n)));
    chk("R7 afull_n", 32'(afull_n), 32'(!(c >= N - cur_m)));
  endtask

  task automatic master_reset(input bit mode, input int n, input int m);
    cur_n         = n;
    cur_m         = m;
    ae_offset     = AW'(n);
    af_offset     = AW'(m);
    sync_mode_sel = mode;
    mrst_n        = 1'b0;
    repeat (4) @(negedge wr_clk);
    mrst_n = 1'b1;
    settle();
  endtask

  // Offsets 2/2: afull at 6 words, aempty at 2 or fewer. Starts empty, ends empty.
  task automatic mode_probe(input bit sync_exp, input logic [DW-1:0] base, input string tag);
    for (int k = 0; k < 5; k++) push(base + DW'(k));
    settle();
    push(base + DW'(5));
    chk({tag, " R9 afull edge"}, 32'(afull_n), 32'(sync_exp));
    @(negedge wr_clk);
    chk({tag, " R9 afull next"}, 32'(afull_n), 32'(0));
    settle();
    pop();
    chk({tag, " R1 first word"}, 32'(rd_data), 32'(base));
    settle();
    pop();
    settle();
    pop();
    settle();
    pop();
    chk({tag, " R9 aempty edge"}, 32'(aempty_n), 32'(sync_exp));
    @(negedge rd_clk);
    chk({tag, " R9 aempty next"}, 32'(aempty_n), 32'(0));
    settle();
    pop();
    pop();
    settle();
    check_flags(0);
  endtask

  initial begin
    mrst_n = 1'b0; prst_n = 1'b1; oe_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_data = '0; sync_mode_sel = 1'b1; ae_offset = '0; af_offset = '0;

    // R2: reset state
    master_reset(1'b1, 1, 1);
    chk("R2 rd_data after reset", 32'(rd_data), 32'(0));
    check_flags(0);

    // R2: master reset from a non-empty state with a loaded output register
    push(16'h1111); push(16'h2222); push(16'h3333);
    settle();
    pop();
    chk("R1 data", 32'(rd_data), 32'h1111);
    master_reset(1'b1, 1, 1);
    chk("R2 rd_data cleared", 32'(rd_data), 32'(0));
    check_flags(0);

    // Sweep of fill levels under several offset/mode combinations (R1,R3..R7)
    for (int cfg = 0; cfg < 4; cfg++) begin
      int n, m;
      bit md;
      n  = (cfg == 0) ? 0 : (cfg == 1) ? 2 : (cfg == 2) ? 5 : 7;
      m  = (cfg == 0) ? 0 : (cfg == 1) ? 3 : (cfg == 2) ? 1 : 7;
      md = (cfg % 2) == 0;
      master_reset(md, n, m);
      check_flags(0);
      for (int i = 0; i < N; i++) begin
        push(16'(cfg * 256 + i));
        settle();
        check_flags(i + 1);
      end
      push(16'hdead);               // R3: ignored while full
      settle();
      check_flags(N);
      for (int i = 0; i < N; i++) begin
        pop();
        chk("R1 order", 32'(rd_data), 32'(cfg * 256 + i));
        settle();
        check_flags(N - 1 - i);
      end
      pop();                        // R3: ignored while empty
      settle();
      chk("R3 rd_data held", 32'(rd_data), 32'(cfg * 256 + N - 1));
      check_flags(0);
    end

    // R9: timing mode difference
    master_reset(1'b1, 2, 2);
    mode_probe(1'b1, 16'h4000, "sync");
    master_reset(1'b0, 2, 2);
    mode_probe(1'b0, 16'h5000, "async");

    // R8: partial reset keeps the async mode, clears data path
    push(16'h0abc); push(16'h0def); push(16'h0123); push(16'h0456);
    settle();
    pop();
    chk("R1 data before prst", 32'(rd_data), 32'h0abc);
    sync_mode_sel = 1'b1;
    prst_n = 1'b0;
    repeat (4) @(negedge wr_clk);
    prst_n = 1'b1;
    settle();
    chk("R8 rd_data cleared", 32'(rd_data), 32'(0));
    check_flags(0);
    mode_probe(1'b0, 16'h6000, "R8 retained");

    // R10: output enable
    push(16'h7777);
    settle();
    pop();
    oe_n = 1'b1;
    #1;
    checks++;
    if (rd_data !== {DW{1'bz}}) begin
      fails++;
      $display("FAIL R10 high-z: actual %0h expected zzzz", rd_data);
    end
    oe_n = 1'b0;
    #1;
    chk("R10 driven", 32'(rd_data), 32'h7777);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule